// File: doc/BRIEF.md
# Central Fixed/Rotating Bus Priority Resolver

This block sits in the middle of a shared system bus that several independent bus arbiters use. Each arbiter drives one request line into the resolver. The resolver returns a one-hot priority-in vector: at most one arbiter sees its priority line asserted at any time. An arbiter that holds priority waits until the shared bus is idle, then takes it. The resolver also watches the shared busy level. From that level it learns when an owner has finished.

Two ordering modes can be selected. In fixed mode the lowest-numbered active request wins. The block first encodes that request to a binary slot index, then decodes the index back to a single priority line. In rotating mode the same encode/decode path starts its search at a moving pointer. When an owner frees the bus, the pointer moves to the slot just after that owner, so every requester gets a turn over time. All outputs are registered on the bus clock, so they are settled before any arbiter samples them.

Top module: `arb_resolver`

## Requirements
- R1: `prio_o` has at most one bit set in every cycle.
- R2: When `rot_sel_i` is 0 (fixed mode) at a clock edge, the lowest-numbered active bit of `req_i` is granted from that edge on: its `prio_o` bit is set and `grant_idx_o` holds its number.
- R3: Whenever `grant_valid_o` is 1, `prio_o` equals a single 1 shifted left by `grant_idx_o`.
- R4: When `req_i` is all zero at an edge, after that edge `prio_o` is zero, `grant_valid_o` is 0 and `grant_idx_o` is 0. Any nonzero `req_i` gives `grant_valid_o` = 1 after the edge.
- R5: All outputs are registered. They change only at a rising clock edge and reflect the inputs sampled at that edge. Input changes between edges leave them untouched.
- R6: When `rot_sel_i` is 1 (rotating mode) and the mode did not change at that edge, the search starts at the rotation pointer and goes up through the slots, wrapping from NUM_ARB-1 to 0. The first active slot found is granted.
- R7: `bus_idle_i` is 1 when the bus is free and 0 when it is occupied. At an edge where it is sampled going from 1 to 0, the granted slot on the outputs at that moment (if valid) is recorded as the owner. In rotating mode, at an edge where it is sampled going from 0 to 1, the pointer becomes owner+1 modulo NUM_ARB. The new pointer is used from the next edge on.
- R8: At an edge where `rot_sel_i` differs from its value at the previous edge, the pointer is reset to slot 0. The grant made at that same edge searches from slot 0.
- R9: In rotating mode, when every requester keeps requesting and the bus is taken and released once per grant, no requesting slot waits more than NUM_ARB-1 (seven) ownerships between two of its own.
- R10: During reset the outputs are zero, the pointer and owner are 0, the mode history is fixed, and the bus is taken to be idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_ARB | One request line per arbiter |
| rot_sel_i | input | 1 | Ordering mode: 0 fixed, 1 rotating |
| bus_idle_i | input | 1 | Shared busy level; 1 means the bus is free |
| prio_o | output | NUM_ARB | One-hot priority-in lines, one per arbiter |
| grant_idx_o | output | $clog2(NUM_ARB) | Binary index of the granted slot, 0 when none |
| grant_valid_o | output | 1 | High when some slot holds priority |

## Verification
Every grant output is due exactly one rising edge after the inputs that cause it. The bench drives inputs on the falling edge and updates its own model at the following rising edge. It compares 1 ns later, so every comparison lands in the cycle in which the result first shows. Pointer moves from a sampled release only take effect one edge after that release. The model therefore applies them to the next step, never the current one. The stability check changes `req_i` in the middle of a cycle. It then looks at the outputs before the next edge and puts the old value back before that edge.

// File: rtl/arb_res_pkg.sv
package arb_res_pkg;

    // Ordering mode, taken from the mode select pin every clock
    typedef enum logic {
        MODE_FIXED  = 1'b0,
        MODE_ROTATE = 1'b1
    } prio_mode_e;

    // Largest number of arbiters the resolver is meant for
    localparam int MAX_ARB = 8;

endpackage

// File: rtl/arb_prio_encoder.sv
// Finds the first active request, starting at a given slot and wrapping.
module arb_prio_encoder #(
    parameter int NUM   = 8,
    parameter int IDX_W = 3
) (
    input  logic [NUM-1:0]   req_i,
    input  logic [IDX_W-1:0] start_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             hit_o
);
    localparam int SUM_W = IDX_W + 1;

    always_comb begin
        idx_o = '0;
        hit_o = 1'b0;
        // Walk from the farthest offset down, so the nearest hit is the last write
        for (int off = NUM - 1; off >= 0; off--) begin
            logic [SUM_W-1:0] pos;
            pos = {1'b0, start_i} + SUM_W'(off);
            if (pos >= SUM_W'(NUM)) begin
                pos = pos - SUM_W'(NUM);
            end
            if (req_i[pos[IDX_W-1:0]]) begin
                idx_o = pos[IDX_W-1:0];
                hit_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/arb_onehot_decoder.sv
// Turns a binary slot index back into one priority line.
module arb_onehot_decoder #(
    parameter int NUM   = 8,
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic             en_i,
    output logic [NUM-1:0]   oh_o
);
    for (genvar g = 0; g < NUM; g++) begin : g_line
        assign oh_o[g] = en_i && (idx_i == IDX_W'(g));
    end

endmodule

// File: rtl/arb_resolver.sv
module arb_resolver
    import arb_res_pkg::*;
#(
    parameter int NUM_ARB = MAX_ARB,
    parameter int IDX_W   = (NUM_ARB > 1) ? $clog2(NUM_ARB) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_ARB-1:0] req_i,
    input  logic               rot_sel_i,
    input  logic               bus_idle_i,
    output logic [NUM_ARB-1:0] prio_o,
    output logic [IDX_W-1:0]   grant_idx_o,
    output logic               grant_valid_o
);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NUM_ARB - 1);

    typedef struct packed {
        logic [NUM_ARB-1:0] prio;
        logic [IDX_W-1:0]   idx;
        logic               valid;
        logic [IDX_W-1:0]   ptr;
        logic [IDX_W-1:0]   owner;
        logic               idle_hist;
        prio_mode_e         mode;
    } state_t;

    localparam state_t RST_STATE = '{
        prio:      '0,
        idx:       '0,
        valid:     1'b0,
        ptr:       '0,
        owner:     '0,
        idle_hist: 1'b1,
        mode:      MODE_FIXED
    };

    state_t s_d, s_q;

    prio_mode_e         mode_in;
    logic               mode_chg;
    logic [IDX_W-1:0]   search_start;
    logic [IDX_W-1:0]   enc_idx;
    logic               enc_hit;
    logic [NUM_ARB-1:0] dec_oh;
    logic               took_bus;
    logic               freed_bus;
    logic [IDX_W-1:0]   after_owner;

    assign mode_in      = prio_mode_e'(rot_sel_i);
    assign mode_chg     = (mode_in != s_q.mode);
    // A fresh mode always searches from slot 0; fixed mode never rotates
    assign search_start = (mode_in == MODE_ROTATE && !mode_chg) ? s_q.ptr : '0;
    assign took_bus     = s_q.idle_hist && !bus_idle_i;
    assign freed_bus    = !s_q.idle_hist && bus_idle_i;
    assign after_owner  = (s_q.owner == LAST_SLOT) ? '0 : s_q.owner + 1'b1;

    arb_prio_encoder #(
        .NUM   (NUM_ARB),
        .IDX_W (IDX_W)
    ) u_enc (
        .req_i   (req_i),
        .start_i (search_start),
        .idx_o   (enc_idx),
        .hit_o   (enc_hit)
    );

    arb_onehot_decoder #(
        .NUM   (NUM_ARB),
        .IDX_W (IDX_W)
    ) u_dec (
        .idx_i (enc_idx),
        .en_i  (enc_hit),
        .oh_o  (dec_oh)
    );

    always_comb begin
        s_d           = s_q;
        s_d.prio      = dec_oh;
        s_d.idx       = enc_hit ? enc_idx : '0;
        s_d.valid     = enc_hit;
        s_d.mode      = mode_in;
        s_d.idle_hist = bus_idle_i;

        // Whoever held priority when the bus was taken is the owner
        if (took_bus && s_q.valid) begin
            s_d.owner = s_q.idx;
        end

        if (mode_chg) begin
            s_d.ptr = '0;
        end else if (mode_in == MODE_ROTATE && freed_bus) begin
            s_d.ptr = after_owner;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= RST_STATE;
        end else begin
            s_q <= s_d;
        end
    end

    assign prio_o        = s_q.prio;
    assign grant_idx_o   = s_q.idx;
    assign grant_valid_o = s_q.valid;

endmodule

// File: rtl/arb_resolver_chk.sv
module arb_resolver_chk #(
    parameter int NUM_ARB = 8,
    parameter int IDX_W   = 3
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_ARB-1:0] req_i,
    input logic               rot_sel_i,
    input logic [NUM_ARB-1:0] prio_o,
    input logic [IDX_W-1:0]   grant_idx_o,
    input logic               grant_valid_o
);
    // R1
    onehot_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(prio_o));

    // R3
    idx_matches_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_valid_o |-> prio_o[grant_idx_o]);

    // R4
    idle_lines_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !grant_valid_o |-> (prio_o == '0 && grant_idx_o == '0));

    // R4
    request_gets_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i != '0) |=> grant_valid_o);

    // R2
    fixed_lowest_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rot_sel_i && req_i != '0) |=>
            (prio_o == ($past(req_i) & (~$past(req_i) + 1'b1))));

endmodule

bind arb_resolver arb_resolver_chk #(
    .NUM_ARB (NUM_ARB),
    .IDX_W   (IDX_W)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (req_i),
    .rot_sel_i     (rot_sel_i),
    .prio_o        (prio_o),
    .grant_idx_o   (grant_idx_o),
    .grant_valid_o (grant_valid_o)
);

// File: tb/test_arb_resolver.sv
module test_arb_resolver;
    localparam int N = 8;
    localparam int W = 3;

    logic         clk   = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req   = '0;
    logic         rot   = 1'b0;
    logic         idle  = 1'b1;
    logic [N-1:0] prio;
    logic [W-1:0] gidx;
    logic         gval;

    int vectors = 0;
    int errors  = 0;

    // Bench model state, built from the requirements
    logic [N-1:0] e_prio  = '0;
    int           e_idx   = 0;
    logic         e_val   = 1'b0;
    int           m_ptr   = 0;
    int           m_owner = 0;
    logic         m_idleh = 1'b1;
    logic         m_mode  = 1'b0;
    int           waits [N];

    always #5 clk = ~clk;

    arb_resolver #(.NUM_ARB(N)) i_arb_resolver (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .req_i         (req),
        .rot_sel_i     (rot),
        .bus_idle_i    (idle),
        .prio_o        (prio),
        .grant_idx_o   (gidx),
        .grant_valid_o (gval)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "prio", int'(prio), int'(e_prio));
        check(tag, "valid", int'(gval), int'(e_val));
        check(tag, "index", int'(gidx), e_idx);
        check("R1", "ones in prio", $countones(prio) > 1 ? 1 : 0, 0);
        if (gval) check("R3", "line vs index", int'(prio), int'(N'(1) << gidx));
    endtask

    task automatic step(input logic [N-1:0] r, input logic m, input logic b, input string tag);
        logic chg, fall, rise;
        int   st, hit, nptr, nown;
        @(negedge clk);
        req = r; rot = m; idle = b;
        @(posedge clk);
        chg = (m != m_mode);
        st  = (m && !chg) ? m_ptr : 0;
        hit = -1;
        for (int k = 0; k < N; k++) begin
            int p;
            p = (st + k) % N;
            if (hit < 0 && r[p]) hit = p;
        end
        fall = m_idleh && !b;
        rise = !m_idleh && b;
        nown = (fall && e_val) ? e_idx : m_owner;
        nptr = chg ? 0 : ((m && rise) ? (m_owner + 1) % N : m_ptr);
        m_owner = nown; m_ptr = nptr; m_idleh = b; m_mode = m;
        e_val  = (hit >= 0);
        e_idx  = e_val ? hit : 0;
        e_prio = e_val ? (N'(1) << hit) : '0;
        #1;
        compare(tag);
    endtask

    // One ownership: settle, take the bus, hold, release
    task automatic tenure(input logic [N-1:0] r, input string tag);
        int g;
        step(r, 1'b1, 1'b1, tag);
        g = int'(gidx);
        if (gval) begin
            for (int s = 0; s < N; s++) begin
                if (r[s]) begin
                    if (s == g) waits[s] = 0;
                    else waits[s]++;
                    check("R9", "wait count within limit", waits[s] > N - 1 ? 1 : 0, 0);
                end
            end
        end
        step(r, 1'b1, 1'b0, tag);
        step(r, 1'b1, 1'b0, tag);
        step(r, 1'b1, 1'b1, tag);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL R5 watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        check("R10", "prio in reset", int'(prio), 0);
        check("R10", "valid in reset", int'(gval), 0);
        check("R10", "index in reset", int'(gidx), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: no requests at all
        step('0, 1'b0, 1'b1, "R4");

        // R2: every request pattern in fixed mode
        for (int r = 0; r < (1 << N); r++) begin
            step(N'(r), 1'b0, 1'b1, "R2");
        end

        // R5: mid-cycle input change leaves registered outputs alone
        step(8'h10, 1'b0, 1'b1, "R5");
        @(negedge clk);
        req = 8'h01;
        #2;
        check("R5", "prio held between edges", int'(prio), 32'h10);
        check("R5", "index held between edges", int'(gidx), 4);
        req = 8'h10;

        // R6, R7: rotation with all requesting, then a sparse pattern
        step(8'hFF, 1'b1, 1'b1, "R8");
        for (int s = 0; s < N; s++) waits[s] = 0;
        for (int t = 0; t < 3 * N; t++) tenure(8'hFF, "R7");
        for (int s = 0; s < N; s++) waits[s] = 0;
        for (int t = 0; t < 3 * N; t++) tenure(8'hA5, "R6");

        // R8: mode change resets the pointer, both ways
        tenure(8'hFF, "R7");
        step(8'hF8, 1'b0, 1'b1, "R8");
        step(8'hFF, 1'b1, 1'b1, "R8");
        tenure(8'hFF, "R8");
        tenure(8'hFF, "R8");
        step(8'hFF, 1'b0, 1'b1, "R8");
        step(8'hFF, 1'b1, 1'b1, "R8");

        // R1: mixed random traffic with mode flips and bus activity
        for (int i = 0; i < 3000; i++) begin
            logic m, b;
            m = ($urandom % 23 == 0) ? ~m_mode : m_mode;
            b = ($urandom % 3 == 0) ? ~m_idleh : m_idleh;
            step(N'($urandom), m, b, "R1");
        end

        finish_run();
    end

endmodule